// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Divider

This unit computes the 32-bit quotient of a numerator and a denominator. A mode input picks unsigned or two's-complement signed division, and both modes share one datapath. An operation begins when `start` is high while the unit is idle. The operands and the mode are captured at that edge. Signed operands become magnitudes first. A restoring shift-subtract loop then produces one quotient bit per iteration, and the quotient is negated at the end when exactly one operand was negative. This makes the signed result truncate toward zero. The remainder is not returned.

The loop runs only as many iterations as the quotient can have bits. That number comes from the distance between the leading ones of the two magnitudes. Small quotients therefore finish sooner. A zero denominator, or a denominator larger than the numerator, skips the loop and completes in a fixed short time. `done` is a one-cycle pulse and the quotient is held until the next result. `busy` covers the whole operation, and a start that arrives while busy is dropped.

Top module: `int_divider`

## Requirements
- R1: With `is_signed` low, both operands are unsigned and `quotient` equals floor(numer / denom). For example, 4/15 gives 0 and 0x80000000/0x40000000 gives 2.
- R2: With `is_signed` high, both operands are two's complement and the quotient truncates toward zero. For example, 15/4 gives 3, -15/4 gives -3, 4/-3 gives -1 and -4/-3 gives 1.
- R3: In signed mode, 0x80000000 divided by 0xFFFFFFFF (-2^31 / -1) returns 0x80000000. No overflow indication is raised.
- R4: A zero denominator gives a quotient of 0 with `div_by_zero` high in the same cycle as `done`. `done` rises on the second rising edge after the edge that accepts `start`.
- R5: When the denominator magnitude is nonzero and exceeds the numerator magnitude, the quotient is 0 and `div_by_zero` stays low. `done` comes at the same fixed latency as in R4.
- R6: In every other case, `done` rises on rising edge 3+k after the accepting edge. Here k is the bit index of the numerator magnitude's leading one minus that of the denominator magnitude.
- R7: `busy` is high from the edge that accepts `start` until the edge that raises `done`. A `start` seen while `busy` is high is ignored: it changes neither the running result nor the number of `done` pulses.
- R8: `done` is high for exactly one cycle per accepted operation. `div_by_zero` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; accepted when `busy` is low |
| is_signed | input | 1 | 1 = signed operands, 0 = unsigned |
| numer | input | 32 | Numerator |
| denom | input | 32 | Denominator |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| div_by_zero | output | 1 | Denominator was zero; high only with `done` |
| quotient | output | 32 | Quotient, held after `done` |

## Verification
The assertions assume that `numer`, `denom` and `is_signed` are meaningful only on the edge where `start` meets an idle unit. They keep their own copy of the operands taken at that edge, so changes to the inputs afterwards do not matter. The stimulus changes inputs only on falling edges. It holds `start` for one cycle per request and waits for `busy` to fall before the next request. The one exception is a deliberate start pulse with different operands while busy. Operands include 0, 1, -1, -2^31 and 0xFFFFFFFF in both modes, alongside random values and values shifted to random widths so that many quotient lengths are reached.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2,
    ST_FIN  = 2'd3
  } div_state_e;
endpackage

// File: rtl/div_prep.sv
// Operand conditioning: magnitudes, result sign, early-exit tests, loop length.
module div_prep #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic          sgn,
  output logic [W-1:0]  mag_a,
  output logic [W-1:0]  mag_b,
  output logic          neg_res,
  output logic          b_zero,
  output logic          b_gt_a,
  output logic [CW-1:0] shift
);
  logic [CW-1:0] lead_a, lead_b;

  always_comb begin
    mag_a   = (sgn && opa[W-1]) ? (~opa + 1'b1) : opa;
    mag_b   = (sgn && opb[W-1]) ? (~opb + 1'b1) : opb;
    neg_res = sgn && (opa[W-1] ^ opb[W-1]);
    b_zero  = (opb == '0);
    b_gt_a  = (mag_b > mag_a);
  end

  always_comb begin
    lead_a = '0;
    lead_b = '0;
    for (int i = 0; i < W; i++) begin
      if (mag_a[i]) lead_a = CW'(i);
      if (mag_b[i]) lead_b = CW'(i);
    end
    shift = lead_a - lead_b;
  end
endmodule

// File: rtl/div_iter.sv
// Restoring loop: one quotient bit per step, divisor pre-aligned to the numerator.
module div_iter #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [W-1:0]  mag_a,
  input  logic [W-1:0]  mag_b,
  input  logic [CW-1:0] shift,
  output logic [W-1:0]  q,
  output logic          last
);
  logic [W-1:0]  rem_q, rem_d, dsh_q, dsh_d, q_q, q_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  assign en = load | step;

  always_comb begin
    rem_d = rem_q;
    dsh_d = dsh_q;
    q_d   = q_q;
    cnt_d = cnt_q;
    if (load) begin
      rem_d = mag_a;
      dsh_d = mag_b << shift;
      q_d   = '0;
      cnt_d = shift;
    end else if (step) begin
      if (rem_q >= dsh_q) begin
        rem_d = rem_q - dsh_q;
        q_d   = {q_q[W-2:0], 1'b1};
      end else begin
        q_d   = {q_q[W-2:0], 1'b0};
      end
      dsh_d = dsh_q >> 1;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dsh_q <= '0;
      q_q   <= '0;
      cnt_q <= '0;
    end else if (en) begin
      rem_q <= rem_d;
      dsh_q <= dsh_d;
      q_q   <= q_d;
      cnt_q <= cnt_d;
    end
  end

  assign q    = q_q;
  assign last = (cnt_q == '0);
endmodule

// File: rtl/int_divider.sv
module int_divider
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] numer,
  input  logic [W-1:0] denom,
  output logic         busy,
  output logic         done,
  output logic         div_by_zero,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W);

  div_state_e    st_q, st_d;
  logic [W-1:0]  a_q, b_q;
  logic          sgn_q, zres_q, zres_d;
  logic [W-1:0]  mag_a, mag_b, q_raw, res_d, quo_q;
  logic          neg_res, b_zero, b_gt_a, last;
  logic [CW-1:0] shift;
  logic          accept, load, step, fin;
  logic          done_q, dbz_q;

  assign accept = start && (st_q == ST_IDLE);
  assign fin    = (st_q == ST_FIN);

  div_prep #(.W(W), .CW(CW)) u_prep (
    .opa(a_q), .opb(b_q), .sgn(sgn_q),
    .mag_a(mag_a), .mag_b(mag_b), .neg_res(neg_res),
    .b_zero(b_zero), .b_gt_a(b_gt_a), .shift(shift)
  );

  div_iter #(.W(W), .CW(CW)) u_iter (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .mag_a(mag_a), .mag_b(mag_b), .shift(shift),
    .q(q_raw), .last(last)
  );

  always_comb begin
    st_d   = st_q;
    zres_d = zres_q;
    load   = 1'b0;
    step   = 1'b0;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_PREP;
      ST_PREP: begin
        if (b_zero || b_gt_a) begin
          zres_d = 1'b1;
          st_d   = ST_FIN;
        end else begin
          zres_d = 1'b0;
          load   = 1'b1;
          st_d   = ST_RUN;
        end
      end
      ST_RUN: begin
        step = 1'b1;
        if (last) st_d = ST_FIN;
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (zres_q)       res_d = '0;
    else if (neg_res) res_d = ~q_raw + 1'b1;
    else              res_d = q_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      zres_q <= 1'b0;
      done_q <= 1'b0;
      dbz_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      zres_q <= zres_d;
      done_q <= fin;
      dbz_q  <= fin && b_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      sgn_q <= 1'b0;
    end else if (accept) begin
      a_q   <= numer;
      b_q   <= denom;
      sgn_q <= is_signed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   quo_q <= '0;
    else if (fin) quo_q <= res_d;
  end

  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign div_by_zero = dbz_q;
  assign quotient    = quo_q;
endmodule

// File: rtl/int_divider_chk.sv
module int_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         is_signed,
  input logic [W-1:0] numer,
  input logic [W-1:0] denom,
  input logic         busy,
  input logic         done,
  input logic         div_by_zero,
  input logic [W-1:0] quotient
);
  logic [W-1:0] cap_n, cap_d;
  logic         cap_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_n <= '0;
      cap_d <= '0;
      cap_s <= 1'b0;
    end else if (start && !busy) begin
      cap_n <= numer;
      cap_d <= denom;
      cap_s <= is_signed;
    end
  end

  assert_unsigned_quot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cap_s && cap_d != '0) |-> (quotient == cap_n / cap_d));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_s && cap_n == {1'b1, {(W-1){1'b0}}} && cap_d == '1)
      |-> (quotient == {1'b1, {(W-1){1'b0}}}));

  assert_zero_denom_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_d == '0) |-> (div_by_zero && quotient == '0));

  assert_busy_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_dbz_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_by_zero |-> done);
endmodule

bind int_divider int_divider_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
  .numer(numer), .denom(denom), .busy(busy), .done(done),
  .div_by_zero(div_by_zero), .quotient(quotient)
);

// File: tb/int_divider_tb.sv
`timescale 1ns/1ps
module int_divider_tb;
  localparam int W = 32;

  logic         clk, rst_n, start, is_signed;
  logic [W-1:0] numer, denom;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  logic prev_done = 1'b0;

  typedef struct {
    logic [W-1:0] q;
    logic         dbz;
    int           due;
    string        tag;
  } exp_t;
  exp_t sb[$];

  int_divider #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .numer(numer), .denom(denom), .busy(busy), .done(done),
    .div_by_zero(div_by_zero), .quotient(quotient)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lead(input logic [W-1:0] v);
    int p = 0;
    for (int i = 0; i < W; i++) if (v[i]) p = i;
    return p;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic s, input logic [W-1:0] n, input logic [W-1:0] d);
    exp_t e;
    logic [W-1:0] ma, mb, qm;
    logic neg;
    while (busy) @(negedge clk);
    ma  = (s && n[W-1]) ? -n : n;
    mb  = (s && d[W-1]) ? -d : d;
    neg = s && (n[W-1] ^ d[W-1]);
    e.dbz = (d == '0);
    if (d == '0) begin
      e.q = '0; e.due = cyc + 1 + 2; e.tag = "R4";
    end else if (mb > ma) begin
      e.q = '0; e.due = cyc + 1 + 2; e.tag = "R5";
    end else begin
      qm  = ma / mb;
      e.q = neg ? -qm : qm;
      e.due = cyc + 1 + 3 + (lead(ma) - lead(mb));
      if (s && n == 32'h8000_0000 && d == '1) e.tag = "R3";
      else e.tag = s ? "R2" : "R1";
    end
    sb.push_back(e);
    start = 1'b1; is_signed = s; numer = n; denom = d;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R7", "busy after accept", {31'b0, busy}, 32'd1);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (div_by_zero && !done)
        check(1'b0, "R8", "div_by_zero without done", 32'd1, 32'd0);
      if (done) begin
        check(!prev_done, "R8", "done longer than one cycle", 32'd1, 32'd0);
        if (sb.size() == 0) begin
          check(1'b0, "R7", "unexpected done", quotient, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(quotient === e.q, e.tag, "quotient", quotient, e.q);
          check(div_by_zero === e.dbz, e.tag, "div_by_zero",
                {31'b0, div_by_zero}, {31'b0, e.dbz});
          check(cyc == e.due, "R6", "done cycle", cyc, e.due);
        end
      end
      prev_done = done;
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] corners [5];
    rst_n = 1'b0; start = 1'b0; is_signed = 1'b0; numer = '0; denom = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && div_by_zero === 1'b0, "R8",
          "reset outputs", {29'b0, busy, done, div_by_zero}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Unsigned examples (R1)
    issue(1'b0, 32'd15, 32'd4);
    issue(1'b0, 32'd4, 32'd15);
    issue(1'b0, 32'h8000_0000, 32'h4000_0000);
    issue(1'b0, 32'hFFFF_FFFF, 32'd1);
    // Signed examples (R2)
    issue(1'b1, 32'd15, 32'd4);
    issue(1'b1, -32'sd15, 32'd4);
    issue(1'b1, 32'd4, -32'sd3);
    issue(1'b1, -32'sd4, -32'sd3);
    // Overflow corner (R3)
    issue(1'b1, 32'h8000_0000, 32'hFFFF_FFFF);
    // Zero denominator (R4)
    issue(1'b0, 32'd77, 32'd0);
    issue(1'b1, 32'h8000_0000, 32'd0);
    // Denominator larger (R5)
    issue(1'b1, 32'd3, -32'sd7);
    issue(1'b0, 32'd0, 32'd5);

    // Start while busy is ignored (R7)
    issue(1'b0, 32'hFFFF_FFFF, 32'd3);
    start = 1'b1; numer = 32'd9; denom = 32'd0; is_signed = 1'b1;
    @(negedge clk);
    start = 1'b0;

    // Corner grid in both modes
    corners[0] = 32'd0; corners[1] = 32'd1; corners[2] = 32'hFFFF_FFFF;
    corners[3] = 32'h8000_0000; corners[4] = 32'h7FFF_FFFF;
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          issue(m[0], corners[i], corners[j]);

    // Random operands with random widths
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] a, b;
      a = $urandom() >> ($urandom() % 32);
      b = $urandom() >> ($urandom() % 32);
      issue(k[0], a, b);
    end

    while (busy || sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule